// File: doc/BRIEF.md
# Memory Device Power State Controller

This block follows the power state of one DRAM device that is driven by decoded command packets. It watches the row, column-command and column-extended packet strobes. Each strobe comes with a flag that says whether the packet is addressed to this device, and the row packet also has a flag for broadcast. From these the block derives the device's power state: standby, one of three attention variants (plain, write, read), a transitional entry state on the way into nap or power-down, and the settled nap or power-down state.

When the device enters nap or power-down, the block stores the active state it is leaving, so that a later wake restores it. A nap request that carries a relax command stores standby instead. Entry takes a fixed number of cycles, set by a parameter, during which the clock must stay stable. When entry is complete, an ignore flag is raised. Addressed packets then have no effect until an external wake input brings the device back.

Top module: `pwr_state_ctrl`

## Requirements
- R1: Reset gives state code 0 (standby), a saved return code of 0, and a low ignore flag. State codes are: 0 standby, 1 attention, 2 write-attention, 3 read-attention, 4 nap-entry, 5 nap, 6 powerdown-entry, 7 powerdown.
- R2: An addressed, non-broadcast row packet with the activate (1) or attention (2) command moves standby or any attention variant to plain attention (1). Without a relax, nap or powerdown event, an attention variant stays in some attention variant.
- R3: A relax moves any active state to standby (0). A relax is accepted from three sources: an addressed row packet with command 3, a column packet with command 3, and a column-extended packet with its relax bit set.
- R4: A broadcast row packet with activate or attention leaves the state unchanged. A broadcast row packet with relax (3) moves the device to standby. Broadcast nap or powerdown requests are not acted on.
- R5: A column packet addressed to the device with write (1) or read (2) moves an attention variant to write-attention (2) or read-attention (3). In standby it has no effect.
- R6: An addressed row packet with nap (4) or nap-with-relax (6) enters nap-entry (4). The device stays in nap-entry for exactly HOLD_CYC cycles and then reaches nap (5). Nap beats relax when both arrive in the same cycle.
- R7: An addressed row packet with powerdown (5) enters powerdown-entry (6). The device stays there for HOLD_CYC cycles and then reaches powerdown (7).
- R8: On nap or powerdown entry, the state being left is saved as the return code. A wake in nap or powerdown restores it on the next cycle.
- R9: A nap-with-relax request issued from an attention variant saves standby (0) as the return code.
- R10: The ignore flag is high exactly in nap and powerdown. Packets have no effect during entry or while the device is in nap or powerdown.
- R11: Wake has no effect outside nap and powerdown, including during the entry states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake | input | 1 | Exit request from nap or powerdown |
| row_strobe | input | 1 | Row packet valid |
| row_bcast | input | 1 | Row packet is broadcast |
| row_hit | input | 1 | Row packet addresses this device |
| row_cmd | input | 3 | Row command: 0 none, 1 activate, 2 attention, 3 relax, 4 nap, 5 powerdown, 6 nap with relax |
| col_strobe | input | 1 | Column-command packet valid |
| col_hit | input | 1 | Column packet addresses this device |
| col_cmd | input | 2 | Column command: 0 none, 1 write, 2 read, 3 relax |
| colx_strobe | input | 1 | Column-extended packet valid |
| colx_hit | input | 1 | Extended packet addresses this device |
| colx_rlx | input | 1 | Extended packet carries relax |
| pwr_state | output | 3 | Current power state code |
| ret_state | output | 3 | Saved return state code |
| pkt_ignore | output | 1 | Packets to this device are ignored |

## Verification
The main transition logic is driven with the same command on different paths: addressed or broadcast row packets, and column or extended packets. This tells the sources that must act apart from those that must not. Commands are also sent from standby and from each attention variant. This separates commands that depend on the current state, such as write and read, from those that do not. Nap and powerdown entries are run from read-attention, standby and plain attention, with and without a relax. The bench samples the state on every entry cycle, which catches an off-by-one in the hold count. Packets and wakes sent during entry and during the low-power states show whether the ignore window opens at the right cycle.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [2:0] {
    PS_STBY   = 3'd0,
    PS_ATTN   = 3'd1,
    PS_ATTNW  = 3'd2,
    PS_ATTNR  = 3'd3,
    PS_NAPENT = 3'd4,
    PS_NAP    = 3'd5,
    PS_PDNENT = 3'd6,
    PS_PDN    = 3'd7
  } pstate_e;

  localparam logic [2:0] RC_NONE   = 3'd0;
  localparam logic [2:0] RC_ACT    = 3'd1;
  localparam logic [2:0] RC_ATTN   = 3'd2;
  localparam logic [2:0] RC_RLX    = 3'd3;
  localparam logic [2:0] RC_NAP    = 3'd4;
  localparam logic [2:0] RC_PDN    = 3'd5;
  localparam logic [2:0] RC_NAPRLX = 3'd6;

  localparam logic [1:0] CC_NONE = 2'd0;
  localparam logic [1:0] CC_WR   = 2'd1;
  localparam logic [1:0] CC_RD   = 2'd2;
  localparam logic [1:0] CC_RLX  = 2'd3;

  typedef struct packed {
    logic nap;
    logic pdn;
    logic nap_rlx;
    logic rlx;
    logic attn;
    logic wr;
    logic rd;
  } pevt_t;

  function automatic logic is_attn(pstate_e s);
    return (s == PS_ATTN) || (s == PS_ATTNW) || (s == PS_ATTNR);
  endfunction

  function automatic logic is_active(pstate_e s);
    return (s == PS_STBY) || is_attn(s);
  endfunction

  // Next state from an active state, priority: low-power > relax > attention > column op
  function automatic pstate_e active_next(pstate_e s, pevt_t e);
    pstate_e n;
    n = s;
    if (e.nap)                   n = PS_NAPENT;
    else if (e.pdn)              n = PS_PDNENT;
    else if (e.rlx)              n = PS_STBY;
    else if (e.attn)             n = PS_ATTN;
    else if (is_attn(s) && e.rd) n = PS_ATTNR;
    else if (is_attn(s) && e.wr) n = PS_ATTNW;
    return n;
  endfunction

  // Return state stored on low-power entry
  function automatic pstate_e ret_pick(pstate_e s, pevt_t e);
    return e.nap_rlx ? PS_STBY : s;
  endfunction

endpackage

// File: rtl/pwr_cmd_decode.sv
module pwr_cmd_decode
  import pwr_pkg::*;
(
  input  logic       row_strobe,
  input  logic       row_bcast,
  input  logic       row_hit,
  input  logic [2:0] row_cmd,
  input  logic       col_strobe,
  input  logic       col_hit,
  input  logic [1:0] col_cmd,
  input  logic       colx_strobe,
  input  logic       colx_hit,
  input  logic       colx_rlx,
  output pevt_t      evt
);

  logic row_own;
  logic row_any;
  logic col_own;

  assign row_own = row_strobe && row_hit && !row_bcast;
  assign row_any = row_strobe && (row_hit || row_bcast);
  assign col_own = col_strobe && col_hit;

  always_comb begin
    evt         = '0;
    evt.nap     = row_own && ((row_cmd == RC_NAP) || (row_cmd == RC_NAPRLX));
    evt.nap_rlx = row_own && (row_cmd == RC_NAPRLX);
    evt.pdn     = row_own && (row_cmd == RC_PDN);
    evt.attn    = row_own && ((row_cmd == RC_ACT) || (row_cmd == RC_ATTN));
    evt.rlx     = (row_any && (row_cmd == RC_RLX))
               || (col_own && (col_cmd == CC_RLX))
               || (colx_strobe && colx_hit && colx_rlx);
    evt.wr      = col_own && (col_cmd == CC_WR);
    evt.rd      = col_own && (col_cmd == CC_RD);
  end

endmodule

// File: rtl/pwr_hold_timer.sv
module pwr_hold_timer #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_ent,
  output logic done
);

  localparam int CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt;

  assign done = in_ent && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!in_ent || done) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R6: count never passes the hold length
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ent |-> (cnt <= LAST));
  // R7: counter idles at zero outside entry
  p_cnt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ent |=> (cnt == '0));

endmodule

// File: rtl/pwr_ret_store.sv
module pwr_ret_store
  import pwr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    save,
  input  pstate_e save_val,
  output pstate_e ret_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    ret_q <= PS_STBY;
    else if (save) ret_q <= save_val;
  end

  // R8: saved state only changes on a save
  p_ret_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !save |=> $stable(ret_q));
  // R8: saved value is always an active state
  p_ret_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_active(ret_q));

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake,
  input  logic       row_strobe,
  input  logic       row_bcast,
  input  logic       row_hit,
  input  logic [2:0] row_cmd,
  input  logic       col_strobe,
  input  logic       col_hit,
  input  logic [1:0] col_cmd,
  input  logic       colx_strobe,
  input  logic       colx_hit,
  input  logic       colx_rlx,
  output logic [2:0] pwr_state,
  output logic [2:0] ret_state,
  output logic       pkt_ignore
);

  pstate_e st;
  pstate_e ret_q;
  pevt_t   evt;
  logic    st_active;
  logic    st_entry;
  logic    ent_done;
  logic    save_en;
  logic    wake_ok;

  pwr_cmd_decode u_dec (
    .row_strobe (row_strobe),
    .row_bcast  (row_bcast),
    .row_hit    (row_hit),
    .row_cmd    (row_cmd),
    .col_strobe (col_strobe),
    .col_hit    (col_hit),
    .col_cmd    (col_cmd),
    .colx_strobe(colx_strobe),
    .colx_hit   (colx_hit),
    .colx_rlx   (colx_rlx),
    .evt        (evt)
  );

  assign st_active = is_active(st);
  assign st_entry  = (st == PS_NAPENT) || (st == PS_PDNENT);
  assign save_en   = st_active && (evt.nap || evt.pdn);
  assign wake_ok   = wake && ((st == PS_NAP) || (st == PS_PDN));

  pwr_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .in_ent(st_entry),
    .done  (ent_done)
  );

  pwr_ret_store u_ret (
    .clk     (clk),
    .rst_n   (rst_n),
    .save    (save_en),
    .save_val(ret_pick(st, evt)),
    .ret_q   (ret_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= PS_STBY;
    end else begin
      case (st)
        PS_NAPENT: if (ent_done) st <= PS_NAP;
        PS_PDNENT: if (ent_done) st <= PS_PDN;
        PS_NAP, PS_PDN: if (wake_ok) st <= ret_q;
        default:   st <= active_next(st, evt);
      endcase
    end
  end

  assign pwr_state  = st;
  assign ret_state  = ret_q;
  assign pkt_ignore = (st == PS_NAP) || (st == PS_PDN);

  // R2: attention persists without relax or low-power request
  p_attn_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_attn(st) && !evt.rlx && !evt.nap && !evt.pdn) |=> is_attn(st));
  // R3: relax from an active state lands in standby
  p_relax_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_active && evt.rlx && !evt.nap && !evt.pdn) |=> (st == PS_STBY));
  // R6: nap request enters the nap entry state
  p_nap_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_active && evt.nap) |=> (st == PS_NAPENT));
  // R7: powerdown request enters the powerdown entry state
  p_pdn_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_active && evt.pdn) |=> (st == PS_PDNENT));
  // R8: wake restores the saved state
  p_wake_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ok |=> (st == $past(ret_q)));
  // R9: nap with relax from attention saves standby
  p_naprlx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_attn(st) && evt.nap_rlx) |=> (ret_q == PS_STBY));
  // R10: low-power state is held until wake
  p_lp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ignore && !wake) |=> $stable(st));
  // R11: entry states only advance to their low-power state
  p_ent_path_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_NAPENT) |=> ((st == PS_NAPENT) || (st == PS_NAP)));

endmodule

// File: tb/pwr_state_ctrl_tb.sv
`timescale 1ns/100ps
module pwr_state_ctrl_tb;

  localparam int HOLD = 4;

  typedef struct packed {
    logic [2:0] rf;   // {strobe, bcast, hit}
    logic [2:0] rc;
    logic [1:0] cf;   // {strobe, hit}
    logic [1:0] cc;
    logic [2:0] xf;   // {strobe, hit, relax}
    logic       wk;
    logic [2:0] es;
    logic [2:0] er;
    logic       ei;
    logic [3:0] rq;
  } vec_t;

  localparam logic [2:0] R0 = 3'b000, RA = 3'b101, RB = 3'b110;
  localparam logic [1:0] C0 = 2'b00, CH = 2'b11;
  localparam logic [2:0] X0 = 3'b000, XR = 3'b111;
  localparam int NV = 54;

  localparam vec_t TBL [NV] = '{
    '{R0,3'd0,C0,2'd0,X0,1'b0,3'd0,3'd0,1'b0,4'd1},   // R1 idle
    '{RB,3'd1,C0,2'd0,X0,1'b0,3'd0,3'd0,1'b0,4'd4},   // R4 bcast act
    '{RB,3'd2,C0,2'd0,X0,1'b0,3'd0,3'd0,1'b0,4'd4},   // R4 bcast attn
    '{R0,3'd0,CH,2'd1,X0,1'b0,3'd0,3'd0,1'b0,4'd5},   // R5 wr in stby
    '{RA,3'd2,C0,2'd0,X0,1'b0,3'd1,3'd0,1'b0,4'd2},   // R2 attn
    '{R0,3'd0,CH,2'd1,X0,1'b0,3'd2,3'd0,1'b0,4'd5},   // R5 write
    '{R0,3'd0,CH,2'd2,X0,1'b0,3'd3,3'd0,1'b0,4'd5},   // R5 read
    '{R0,3'd0,C0,2'd0,X0,1'b0,3'd3,3'd0,1'b0,4'd2},   // R2 hold
    '{RB,3'd2,C0,2'd0,X0,1'b0,3'd3,3'd0,1'b0,4'd4},   // R4 bcast attn
    '{RA,3'd2,C0,2'd0,X0,1'b0,3'd1,3'd0,1'b0,4'd2},   // R2 back to plain
    '{R0,3'd0,CH,2'd3,X0,1'b0,3'd0,3'd0,1'b0,4'd3},   // R3 col relax
    '{RA,3'd1,C0,2'd0,X0,1'b0,3'd1,3'd0,1'b0,4'd2},   // R2 activate
    '{R0,3'd0,C0,2'd0,XR,1'b0,3'd0,3'd0,1'b0,4'd3},   // R3 ext relax
    '{RA,3'd2,C0,2'd0,X0,1'b0,3'd1,3'd0,1'b0,4'd2},
    '{RA,3'd3,C0,2'd0,X0,1'b0,3'd0,3'd0,1'b0,4'd3},   // R3 row relax
    '{RA,3'd2,C0,2'd0,X0,1'b0,3'd1,3'd0,1'b0,4'd2},
    '{RB,3'd3,C0,2'd0,X0,1'b0,3'd0,3'd0,1'b0,4'd4},   // R4 bcast relax
    '{RA,3'd2,C0,2'd0,X0,1'b0,3'd1,3'd0,1'b0,4'd2},
    '{R0,3'd0,CH,2'd2,X0,1'b0,3'd3,3'd0,1'b0,4'd5},
    '{RA,3'd4,C0,2'd0,X0,1'b0,3'd4,3'd3,1'b0,4'd6},   // R6 nap from read-attn
    '{R0,3'd0,C0,2'd0,X0,1'b1,3'd4,3'd3,1'b0,4'd11},  // R11 wake in entry
    '{RA,3'd2,C0,2'd0,X0,1'b0,3'd4,3'd3,1'b0,4'd10},  // R10 pkt in entry
    '{R0,3'd0,C0,2'd0,X0,1'b0,3'd4,3'd3,1'b0,4'd6},
    '{RA,3'd2,C0,2'd0,X0,1'b0,3'd5,3'd3,1'b1,4'd10},  // R6 nap reached
    '{R0,3'd0,CH,2'd1,X0,1'b0,3'd5,3'd3,1'b1,4'd10},  // R10 col ignored
    '{R0,3'd0,C0,2'd0,X0,1'b1,3'd3,3'd3,1'b0,4'd8},   // R8 wake
    '{RA,3'd6,C0,2'd0,X0,1'b0,3'd4,3'd0,1'b0,4'd9},   // R9 nap+relax
    '{R0,3'd0,C0,2'd0,X0,1'b0,3'd4,3'd0,1'b0,4'd6},
    '{R0,3'd0,C0,2'd0,X0,1'b0,3'd4,3'd0,1'b0,4'd6},
    '{R0,3'd0,C0,2'd0,X0,1'b0,3'd4,3'd0,1'b0,4'd6},
    '{R0,3'd0,C0,2'd0,X0,1'b0,3'd5,3'd0,1'b1,4'd6},
    '{R0,3'd0,C0,2'd0,X0,1'b1,3'd0,3'd0,1'b0,4'd8},   // R8 wake to stby
    '{RA,3'd5,C0,2'd0,X0,1'b0,3'd6,3'd0,1'b0,4'd7},   // R7 pdn from stby
    '{R0,3'd0,C0,2'd0,X0,1'b0,3'd6,3'd0,1'b0,4'd7},
    '{R0,3'd0,C0,2'd0,X0,1'b0,3'd6,3'd0,1'b0,4'd7},
    '{R0,3'd0,C0,2'd0,X0,1'b0,3'd6,3'd0,1'b0,4'd7},
    '{R0,3'd0,C0,2'd0,X0,1'b0,3'd7,3'd0,1'b1,4'd7},   // R7 pdn reached
    '{RB,3'd3,C0,2'd0,X0,1'b0,3'd7,3'd0,1'b1,4'd10},  // R10 bcast relax ignored
    '{R0,3'd0,C0,2'd0,X0,1'b1,3'd0,3'd0,1'b0,4'd8},
    '{RA,3'd2,C0,2'd0,X0,1'b0,3'd1,3'd0,1'b0,4'd2},
    '{RA,3'd5,C0,2'd0,X0,1'b0,3'd6,3'd1,1'b0,4'd7},   // R7 pdn from attn
    '{R0,3'd0,C0,2'd0,X0,1'b0,3'd6,3'd1,1'b0,4'd7},
    '{R0,3'd0,C0,2'd0,X0,1'b0,3'd6,3'd1,1'b0,4'd7},
    '{R0,3'd0,C0,2'd0,X0,1'b0,3'd6,3'd1,1'b0,4'd7},
    '{R0,3'd0,C0,2'd0,X0,1'b0,3'd7,3'd1,1'b1,4'd7},
    '{R0,3'd0,C0,2'd0,X0,1'b1,3'd1,3'd1,1'b0,4'd8},   // R8 back to attn
    '{R0,3'd0,C0,2'd0,X0,1'b1,3'd1,3'd1,1'b0,4'd11},  // R11 wake in attn
    '{RA,3'd4,CH,2'd3,X0,1'b0,3'd4,3'd1,1'b0,4'd6},   // R6 nap beats relax
    '{R0,3'd0,C0,2'd0,X0,1'b0,3'd4,3'd1,1'b0,4'd6},
    '{R0,3'd0,C0,2'd0,X0,1'b0,3'd4,3'd1,1'b0,4'd6},
    '{R0,3'd0,C0,2'd0,X0,1'b0,3'd4,3'd1,1'b0,4'd6},
    '{R0,3'd0,C0,2'd0,X0,1'b0,3'd5,3'd1,1'b1,4'd6},
    '{R0,3'd0,C0,2'd0,X0,1'b1,3'd1,3'd1,1'b0,4'd8},
    '{RA,3'd3,C0,2'd0,X0,1'b0,3'd0,3'd1,1'b0,4'd3}    // R3 relax, ret kept
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wake;
  logic       row_strobe, row_bcast, row_hit;
  logic [2:0] row_cmd;
  logic       col_strobe, col_hit;
  logic [1:0] col_cmd;
  logic       colx_strobe, colx_hit, colx_rlx;
  logic [2:0] pwr_state, ret_state;
  logic       pkt_ignore;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwr_state_ctrl #(.HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .wake(wake),
    .row_strobe(row_strobe), .row_bcast(row_bcast), .row_hit(row_hit),
    .row_cmd(row_cmd), .col_strobe(col_strobe), .col_hit(col_hit),
    .col_cmd(col_cmd), .colx_strobe(colx_strobe), .colx_hit(colx_hit),
    .colx_rlx(colx_rlx), .pwr_state(pwr_state), .ret_state(ret_state),
    .pkt_ignore(pkt_ignore)
  );

  task automatic drive(vec_t v);
    {row_strobe, row_bcast, row_hit} = v.rf;
    row_cmd = v.rc;
    {col_strobe, col_hit} = v.cf;
    col_cmd = v.cc;
    {colx_strobe, colx_hit, colx_rlx} = v.xf;
    wake = v.wk;
  endtask

  task automatic check(int rq, logic [2:0] es, logic [2:0] er, logic ei, int idx);
    checks += 3;
    if (pwr_state !== es) begin
      errors++;
      $display("FAIL R%0d step %0d state act=%0d exp=%0d", rq, idx, pwr_state, es);
    end
    if (ret_state !== er) begin
      errors++;
      $display("FAIL R%0d step %0d ret act=%0d exp=%0d", rq, idx, ret_state, er);
    end
    if (pkt_ignore !== ei) begin
      errors++;
      $display("FAIL R%0d step %0d ignore act=%0d exp=%0d", rq, idx, pkt_ignore, ei);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    vec_t idle;
    idle = '0;
    drive(idle);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(1, 3'd0, 3'd0, 1'b0, -1);   // R1 reset state
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      check(int'(TBL[i].rq), TBL[i].es, TBL[i].er, TBL[i].ei, i);
    end

    // R1: reset mid-run from attention with a non-standby return code
    drive(idle);
    row_strobe = 1'b1; row_hit = 1'b1; row_cmd = 3'd2;
    @(negedge clk);
    row_cmd = 3'd4;
    @(negedge clk);
    check(6, 3'd4, 3'd1, 1'b0, 100);
    drive(idle);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 3'd0, 3'd0, 1'b0, 101);
    rst_n = 1'b1;

    // R9: nap with relax from standby still returns to standby
    row_strobe = 1'b1; row_hit = 1'b1; row_cmd = 3'd6;
    @(negedge clk);
    drive(idle);
    check(9, 3'd4, 3'd0, 1'b0, 102);
    repeat (HOLD) @(negedge clk);
    check(6, 3'd5, 3'd0, 1'b1, 103);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    check(8, 3'd0, 3'd0, 1'b0, 104);

    // R4: broadcast nap request is not acted on
    row_strobe = 1'b1; row_bcast = 1'b1; row_hit = 1'b1; row_cmd = 3'd4;
    @(negedge clk);
    drive(idle);
    check(4, 3'd0, 3'd0, 1'b0, 105);

    finish_run();
  end

endmodule